// File: doc/BRIEF.md
# SMT Register Watermark Limiter

This block sits in front of a physical register allocator that two hardware threads share. Each cycle, each thread may ask for one register. The request is either narrow, or wide, which needs a wide-capable entry. The block keeps two occupancy counts per thread: every register the thread holds, and the wide-capable registers among them. Allocations that the block grants and free events that the pipeline reports keep these counts current.

When only one thread is running, that thread may fill the whole pool. When both threads are active, each thread is limited to a high-water mark in each class. Each thread also keeps a protected minimum. A thread that already holds more than its minimum may take another entry only if free entries remain after setting aside what its sibling still lacks of its own minimum. When both threads qualify in the same cycle and there is room for only one, the thread with more headroom under its cap wins.

The answer for each thread is a registered grant or deny, one cycle after the request. Register selection and fairness policy belong to the allocator behind this block.

Top module: `smt_wm_limiter`

## Requirements
- R1: After reset, grant_o and deny_o are 0 and every per-thread count is zero, so the full pool of TOTAL_REGS entries is free.
- R2: A request is answered one cycle later on exactly one of grant_o or deny_o (bit 0 is thread 0, bit 1 is thread 1). A request from a thread whose thr_active_i bit is 0 is always denied.
- R3: With a single thread active, that thread has no cap. Its narrow requests are granted until all TOTAL_REGS entries are held, and its wide requests are granted until all WIDE_REGS entries are held.
- R4: With both threads active, a thread that holds HWM_ALL registers is denied, even when free entries remain.
- R5: A granted wide request counts against both of the thread's counts. With both threads active, a thread that holds HWM_WIDE wide registers is denied a wide request.
- R6: The caps apply as soon as the sibling is active, even if the sibling holds no registers.
- R7: With both threads active, a thread at or above its minimum in a class (MIN_ALL total, MIN_WIDE wide) is granted only if that class's free count is larger than max(0, minimum minus the sibling's count). A thread below its minimum needs only one free entry.
- R8: A free event lowers the freeing thread's total count by one. A wide free (free_wide_i set) also lowers its wide count by one. Frees take effect for requests in the following cycle.
- R9: If both threads qualify in one cycle, both are granted when at least two entries are free and the wide free count covers the number of wide requests. Otherwise only the thread with the larger headroom (HWM_ALL minus its total count) is granted, and thread 0 wins a tie.
- R10: Deactivating a thread does not clear its counts; its held registers stay unavailable until they are freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active_i | input | 2 | Thread running flags, one bit per thread |
| req_valid_i | input | 2 | Allocation request, one bit per thread |
| req_wide_i | input | 2 | The request needs a wide-capable entry |
| free_valid_i | input | 2 | The thread releases one register this cycle |
| free_wide_i | input | 2 | The released register is wide-capable |
| grant_o | output | 2 | Registered grant, one cycle after the request |
| deny_o | output | 2 | Registered deny, one cycle after the request |

## Verification
The assertions assume that the pipeline frees only registers a thread actually holds: a free never takes a count below zero, and a wide free happens only while the thread holds a wide entry. Under that assumption the occupancy sums stay within the pool sizes and a thread's wide count never exceeds its total count. The stimulus keeps to this rule by issuing a free only for an entry that an earlier checked grant handed to the same thread, in the same class. A second instance with a larger wide pool receives the same inputs, so that the wide cap can be reached before the sibling's reservation takes effect.

// File: rtl/smt_wm_pkg.sv
package smt_wm_pkg;

  localparam int unsigned NTHR = 2;

  typedef enum logic { THR0 = 1'b0, THR1 = 1'b1 } thr_id_t;

  // width of a counter able to hold 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/smt_wm_counter.sv
module smt_wm_counter #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          inc_wide,
  input  logic          dec,
  input  logic          dec_wide,
  output logic [CW-1:0] cnt_all,
  output logic [CW-1:0] cnt_wide
);

  // occupancy of one thread; alloc and free may land in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_all  <= '0;
      cnt_wide <= '0;
    end else begin
      cnt_all  <= cnt_all  + CW'(inc)      - CW'(dec);
      cnt_wide <= cnt_wide + CW'(inc_wide) - CW'(dec_wide);
    end
  end

endmodule

// File: rtl/smt_wm_eligibility.sv
module smt_wm_eligibility #(
  parameter int unsigned CW       = 9,
  parameter int unsigned HWM_ALL  = 221,
  parameter int unsigned HWM_WIDE = 141,
  parameter int unsigned MIN_ALL  = 130,
  parameter int unsigned MIN_WIDE = 106
) (
  input  logic          both_active,
  input  logic          self_active,
  input  logic          req,
  input  logic          wide,
  input  logic [CW-1:0] own_all,
  input  logic [CW-1:0] own_wide,
  input  logic [CW-1:0] sib_all,
  input  logic [CW-1:0] sib_wide,
  input  logic [CW-1:0] free_all,
  input  logic [CW-1:0] free_wide,
  output logic          elig,
  output logic [CW-1:0] headroom
);

  localparam logic [CW-1:0] CAP_A = CW'(HWM_ALL);
  localparam logic [CW-1:0] CAP_W = CW'(HWM_WIDE);
  localparam logic [CW-1:0] FLR_A = CW'(MIN_ALL);
  localparam logic [CW-1:0] FLR_W = CW'(MIN_WIDE);

  logic [CW-1:0] rsv_all, rsv_wide;
  logic          room_ok, cap_ok, guard_all, guard_wide, shared_ok;

  always_comb begin
    // what the sibling still lacks of its protected minimum
    rsv_all  = (sib_all  < FLR_A) ? FLR_A - sib_all  : '0;
    rsv_wide = (sib_wide < FLR_W) ? FLR_W - sib_wide : '0;

    room_ok    = (free_all != '0) && (!wide || (free_wide != '0));
    cap_ok     = (own_all < CAP_A) && (!wide || (own_wide < CAP_W));
    guard_all  = (own_all < FLR_A) || (free_all > rsv_all);
    guard_wide = !wide || (own_wide < FLR_W) || (free_wide > rsv_wide);
    shared_ok  = cap_ok && guard_all && guard_wide;

    elig     = req && self_active && room_ok && (!both_active || shared_ok);
    headroom = (own_all < CAP_A) ? CAP_A - own_all : '0;
  end

endmodule

// File: rtl/smt_wm_pair_resolve.sv
module smt_wm_pair_resolve
  import smt_wm_pkg::*;
#(
  parameter int unsigned CW = 9
) (
  input  logic [1:0]    elig,
  input  logic [1:0]    wide,
  input  logic [CW-1:0] free_all,
  input  logic [CW-1:0] free_wide,
  input  logic [CW-1:0] head0,
  input  logic [CW-1:0] head1,
  output logic [1:0]    grant
);

  logic [1:0] need_w;
  logic       fit_both;
  thr_id_t    winner;

  always_comb begin
    need_w   = {1'b0, wide[0]} + {1'b0, wide[1]};
    fit_both = (free_all >= CW'(2)) && (free_wide >= CW'(need_w));
    winner   = (head0 >= head1) ? THR0 : THR1;
    if (elig == 2'b11) begin
      if (fit_both)            grant = 2'b11;
      else if (winner == THR0) grant = 2'b01;
      else                     grant = 2'b10;
    end else begin
      grant = elig;
    end
  end

endmodule

// File: rtl/smt_wm_limiter.sv
module smt_wm_limiter
  import smt_wm_pkg::*;
#(
  parameter int unsigned TOTAL_REGS = 327,
  parameter int unsigned WIDE_REGS  = 242,
  parameter int unsigned HWM_ALL    = 221,
  parameter int unsigned HWM_WIDE   = 141,
  parameter int unsigned MIN_ALL    = 130,
  parameter int unsigned MIN_WIDE   = 106
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] thr_active_i,
  input  logic [1:0] req_valid_i,
  input  logic [1:0] req_wide_i,
  input  logic [1:0] free_valid_i,
  input  logic [1:0] free_wide_i,
  output logic [1:0] grant_o,
  output logic [1:0] deny_o
);

  localparam int unsigned CW = cnt_width(TOTAL_REGS);
  localparam logic [CW:0] POOL_A = (CW+1)'(TOTAL_REGS);
  localparam logic [CW:0] POOL_W = (CW+1)'(WIDE_REGS);

  logic [NTHR-1:0][CW-1:0] cnt_all_w, cnt_wide_w, head_w;
  logic [NTHR-1:0]         elig_w, grant_d;
  logic [CW:0]             sum_all, sum_wide;
  logic [CW-1:0]           free_all, free_wide;
  logic                    both_active;

  assign both_active = &thr_active_i;

  always_comb begin
    sum_all   = {1'b0, cnt_all_w[0]}  + {1'b0, cnt_all_w[1]};
    sum_wide  = {1'b0, cnt_wide_w[0]} + {1'b0, cnt_wide_w[1]};
    free_all  = (sum_all  >= POOL_A) ? '0 : CW'(POOL_A - sum_all);
    free_wide = (sum_wide >= POOL_W) ? '0 : CW'(POOL_W - sum_wide);
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    smt_wm_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .inc      (grant_d[t]),
      .inc_wide (grant_d[t] & req_wide_i[t]),
      .dec      (free_valid_i[t]),
      .dec_wide (free_valid_i[t] & free_wide_i[t]),
      .cnt_all  (cnt_all_w[t]),
      .cnt_wide (cnt_wide_w[t])
    );

    smt_wm_eligibility #(
      .CW(CW), .HWM_ALL(HWM_ALL), .HWM_WIDE(HWM_WIDE),
      .MIN_ALL(MIN_ALL), .MIN_WIDE(MIN_WIDE)
    ) u_elig (
      .both_active (both_active),
      .self_active (thr_active_i[t]),
      .req         (req_valid_i[t]),
      .wide        (req_wide_i[t]),
      .own_all     (cnt_all_w[t]),
      .own_wide    (cnt_wide_w[t]),
      .sib_all     (cnt_all_w[NTHR-1-t]),
      .sib_wide    (cnt_wide_w[NTHR-1-t]),
      .free_all    (free_all),
      .free_wide   (free_wide),
      .elig        (elig_w[t]),
      .headroom    (head_w[t])
    );
  end

  smt_wm_pair_resolve #(.CW(CW)) u_pair (
    .elig      (elig_w),
    .wide      (req_wide_i),
    .free_all  (free_all),
    .free_wide (free_wide),
    .head0     (head_w[0]),
    .head1     (head_w[1]),
    .grant     (grant_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      deny_o  <= '0;
    end else begin
      grant_o <= grant_d;
      deny_o  <= req_valid_i & ~grant_d;
    end
  end

endmodule

// File: rtl/smt_wm_limiter_chk.sv
module smt_wm_limiter_chk #(
  parameter int unsigned TOTAL_REGS = 327,
  parameter int unsigned WIDE_REGS  = 242,
  parameter int unsigned HWM_ALL    = 221,
  parameter int unsigned HWM_WIDE   = 141,
  parameter int unsigned MIN_ALL    = 130,
  parameter int unsigned MIN_WIDE   = 106,
  parameter int unsigned CW         = 9
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          thr_active,
  input logic [1:0]          req_valid,
  input logic [1:0]          req_wide,
  input logic [1:0]          grant,
  input logic [1:0][CW-1:0]  cnt_all,
  input logic [1:0][CW-1:0]  cnt_wide
);

  localparam logic [CW:0]   POOL_A = (CW+1)'(TOTAL_REGS);
  localparam logic [CW:0]   POOL_W = (CW+1)'(WIDE_REGS);
  localparam logic [CW-1:0] CAP_A  = CW'(HWM_ALL);
  localparam logic [CW-1:0] CAP_W  = CW'(HWM_WIDE);
  localparam logic [CW-1:0] FLR_A  = CW'(MIN_ALL);

  logic [CW:0] sum_a, sum_w, free_a;

  always_comb begin
    sum_a  = {1'b0, cnt_all[0]}  + {1'b0, cnt_all[1]};
    sum_w  = {1'b0, cnt_wide[0]} + {1'b0, cnt_wide[1]};
    free_a = POOL_A - sum_a;
  end

  // R3: held entries never exceed either pool
  a_r3_pool_bound: assert property (@(posedge clk) disable iff (rst)
    (sum_a <= POOL_A) && (sum_w <= POOL_W));

  for (genvar t = 0; t < 2; t++) begin : g_chk
    // R2: a grant answers a request made by a running thread
    a_r2_grant_has_req: assert property (@(posedge clk) disable iff (rst)
      grant[t] |-> $past(req_valid[t] && thr_active[t]));

    // R4: shared mode total cap
    a_r4_total_cap: assert property (@(posedge clk) disable iff (rst)
      (grant[t] && $past(thr_active == 2'b11)) |-> ($past(cnt_all[t]) < CAP_A));

    // R5: shared mode wide cap, and wide count within total count
    a_r5_wide_cap: assert property (@(posedge clk) disable iff (rst)
      (grant[t] && $past(thr_active == 2'b11 && req_wide[t]))
        |-> ($past(cnt_wide[t]) < CAP_W));

    a_r5_wide_in_total: assert property (@(posedge clk) disable iff (rst)
      cnt_wide[t] <= cnt_all[t]);

    // R7: above the minimum, the sibling's shortfall stays free
    a_r7_reserve: assert property (@(posedge clk) disable iff (rst)
      (grant[t] && $past(thr_active == 2'b11) && $past(cnt_all[t] >= FLR_A)
        && $past(cnt_all[1-t] < FLR_A))
        |-> ($past(free_a) > $past({1'b0, FLR_A - cnt_all[1-t]})));
  end

endmodule

bind smt_wm_limiter smt_wm_limiter_chk #(
  .TOTAL_REGS(TOTAL_REGS), .WIDE_REGS(WIDE_REGS),
  .HWM_ALL(HWM_ALL), .HWM_WIDE(HWM_WIDE),
  .MIN_ALL(MIN_ALL), .MIN_WIDE(MIN_WIDE), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .thr_active (thr_active_i),
  .req_valid  (req_valid_i),
  .req_wide   (req_wide_i),
  .grant      (grant_o),
  .cnt_all    (cnt_all_w),
  .cnt_wide   (cnt_wide_w)
);

// File: tb/smt_wm_limiter_bench.sv
module smt_wm_limiter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] act = '0, req = '0, wid = '0, fr = '0, frw = '0;
  logic [1:0] gnt, dny, gnt_alt, dny_alt;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  // main: pool 14 / wide pool 7, caps 8 / 5, minimums 4 / 3
  smt_wm_limiter #(
    .TOTAL_REGS(14), .WIDE_REGS(7), .HWM_ALL(8), .HWM_WIDE(5),
    .MIN_ALL(4), .MIN_WIDE(3)
  ) u_smt_wm_limiter (
    .clk(clk), .rst(rst), .thr_active_i(act), .req_valid_i(req),
    .req_wide_i(wid), .free_valid_i(fr), .free_wide_i(frw),
    .grant_o(gnt), .deny_o(dny)
  );

  // second copy with a wide pool of 10, so the wide cap binds first
  smt_wm_limiter #(
    .TOTAL_REGS(14), .WIDE_REGS(10), .HWM_ALL(8), .HWM_WIDE(5),
    .MIN_ALL(4), .MIN_WIDE(3)
  ) u_smt_wm_limiter_alt (
    .clk(clk), .rst(rst), .thr_active_i(act), .req_valid_i(req),
    .req_wide_i(wid), .free_valid_i(fr), .free_wide_i(frw),
    .grant_o(gnt_alt), .deny_o(dny_alt)
  );

  // {act, req, wide, free, free_wide, expected grant}
  localparam int NROW = 34;
  localparam logic [11:0] TBL [NROW] = '{
    12'b01_10_00_00_00_00, // R2 inactive requester denied
    12'b11_01_00_00_00_01, 12'b11_01_00_00_00_01, 12'b11_01_00_00_00_01,
    12'b11_01_00_00_00_01, 12'b11_01_00_00_00_01, 12'b11_01_00_00_00_01,
    12'b11_01_00_00_00_01, 12'b11_01_00_00_00_01,
    12'b11_01_00_00_00_00, // R4 R6 cap at 8, sibling empty
    12'b11_10_00_00_00_10, 12'b11_10_00_00_00_10, 12'b11_10_00_00_00_10,
    12'b11_10_00_00_00_10, 12'b11_10_00_00_00_10, 12'b11_10_00_00_00_10,
    12'b11_10_00_00_00_00, // pool full
    12'b11_00_00_01_00_00, // R8 free
    12'b11_11_00_00_00_10, // R9 one slot, larger headroom wins
    12'b11_00_00_10_00_00,
    12'b11_00_00_11_00_00,
    12'b11_11_00_00_00_11, // R9 both fit
    12'b11_00_00_11_00_00,
    12'b11_00_00_10_00_00,
    12'b11_11_11_00_00_11, // R9 both wide fit
    12'b01_01_00_00_00_01, // R3 alone, past cap
    12'b01_01_00_00_00_01,
    12'b01_01_00_00_00_00, // R10 sibling still holds 5
    12'b11_10_00_00_00_00,
    12'b11_00_00_01_00_00,
    12'b11_01_00_00_00_00, // R4 cap with a free entry
    12'b11_10_00_00_00_10,
    12'b11_00_00_10_10_00, // R8 wide free
    12'b11_10_10_00_00_10
  };

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic [1:0] r, input logic [1:0] w,
                      input logic [1:0] f, input logic [1:0] fw);
    act = a; req = r; wid = w; fr = f; frw = fw;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    act = '0; req = '0; wid = '0; fr = '0; frw = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    do_reset();
    chk("R1 reset grant", gnt, 2'b00);
    chk("R1 reset deny", dny, 2'b00);

    for (int i = 0; i < NROW; i++) begin
      logic [11:0] v;
      v = TBL[i];
      step(v[11:10], v[9:8], v[7:6], v[5:4], v[3:2]);
      chk($sformatf("R2 R4 R6 R9 R10 table row %0d grant", i), gnt, v[1:0]);
      chk($sformatf("R2 table row %0d deny", i), dny, v[9:8] & ~v[1:0]);
    end

    // R1 R3: after reset the whole pool of 14 goes to a lone thread
    do_reset();
    for (int i = 0; i < 15; i++) begin
      step(2'b01, 2'b01, 2'b00, 2'b00, 2'b00);
      chk($sformatf("R3 lone fill %0d", i), gnt, (i < 14) ? 2'b01 : 2'b00);
    end

    // R7 (main) and R5 (alt): wide requests with the sibling empty
    do_reset();
    for (int i = 0; i < 6; i++) begin
      step(2'b11, 2'b01, 2'b01, 2'b00, 2'b00);
      chk($sformatf("R7 wide reserve %0d", i), gnt, (i < 4) ? 2'b01 : 2'b00);
      chk($sformatf("R5 wide cap %0d", i), gnt_alt, (i < 5) ? 2'b01 : 2'b00);
    end
    // R5: the five wide grants also count toward the total cap in alt
    for (int i = 0; i < 4; i++) begin
      step(2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
      chk($sformatf("R5 wide in total main %0d", i), gnt, 2'b01);
      chk($sformatf("R5 wide in total alt %0d", i), gnt_alt, (i < 3) ? 2'b01 : 2'b00);
    end

    // R3 R8: lone thread fills the wide pool, frees one, gets it back
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(2'b01, 2'b01, 2'b01, 2'b00, 2'b00);
      chk($sformatf("R3 wide pool %0d", i), gnt, (i < 7) ? 2'b01 : 2'b00);
    end
    step(2'b01, 2'b00, 2'b00, 2'b01, 2'b01);
    chk("R8 free cycle", gnt, 2'b00);
    step(2'b01, 2'b01, 2'b01, 2'b00, 2'b00);
    chk("R8 wide reuse", gnt, 2'b01);

    // R9 tie: equal headroom, one wide slot left, thread 0 wins
    do_reset();
    for (int i = 0; i < 3; i++) begin
      step(2'b11, 2'b01, 2'b01, 2'b00, 2'b00);
      chk($sformatf("R9 setup t0 %0d", i), gnt, 2'b01);
    end
    for (int i = 0; i < 3; i++) begin
      step(2'b11, 2'b10, 2'b10, 2'b00, 2'b00);
      chk($sformatf("R9 setup t1 %0d", i), gnt, 2'b10);
    end
    step(2'b11, 2'b11, 2'b11, 2'b00, 2'b00);
    chk("R9 tie grant", gnt, 2'b01);
    chk("R2 tie deny", dny, 2'b10);

    step(2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    summary();
    $finish;
  end

endmodule